// File: doc/BRIEF.md
# Receive Circular Frame Buffer Manager

This block sits behind a frame receiver and parks every incoming frame in a circular memory of 32-bit words. Bytes of the frame in progress are packed little-endian into words, and each finished word goes out on a write port to an external dual-port memory. Three pointers govern the ring: the oldest byte still owned by the consumer (bottom), the end of the last accepted frame (top), and the next word to write (write pointer). Everything between top and the write pointer is provisional.

When the upstream checker signals a good frame end, the manager accepts the frame. It moves top up to the write pointer and, in the same cycle, pushes the frame's byte count into a small length queue. It rejects the frame instead when the checker reports a bad end, when the ring ran out of room during the frame, or when the length queue is full. A rejected frame is undone by moving the write pointer back to top, so the next frame overwrites it.

Consumers read frame data straight from the memory and take lengths from the queue. Each frame starts on a word boundary, and the first frame after reset starts at word 0, so every frame's position follows from the lengths alone. When a consumer finishes with a frame, it hands the frame's length back on the release input. Frames must be released oldest first.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the length queue is empty (len_valid low), no write is issued, and the first frame's first word is written at word address 0.
- R2: Byte k of a frame (k from 0) is placed in bits [8*(k mod 4)+7 : 8*(k mod 4)] of word k/4. Words go to consecutive addresses starting at top, wrapping modulo the ring size. A word's write is issued in the same cycle as its fourth byte.
- R3: A frame whose length is not a multiple of 4 has its last word written in the end-pulse cycle, with the unused upper byte lanes zero.
- R4: A good end (frame_ok high, frame_bad low) with no overflow and room in the queue pushes the frame's byte count into the length queue. The next frame then starts at the word after the accepted frame's last word.
- R5: A bad end (frame_bad high) pushes nothing, and the next frame starts at the same word address as the rejected frame.
- R6: A word whose write would make the write pointer equal bottom is not written. Its frame writes no further words and is rejected even if it ends good.
- R7: A good end while the length queue already holds 2^FIFO_LOG2 entries is rejected as in R5, and the queue contents are unchanged.
- R8: A release of L bytes advances bottom by ceil(L/4) words modulo the ring size, making that space writable again.
- R9: len_data shows the oldest queued length while len_valid is high. A pulse on len_pop removes that entry, and the head stays stable otherwise.
- R10: A release and a frame acceptance in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A received byte is present |
| in_byte | input | 8 | Received byte |
| frame_ok | input | 1 | End of frame, checks passed (cycle without a byte) |
| frame_bad | input | 1 | End of frame, reception or check failed |
| mem_we | output | 1 | Word write strobe to the ring memory |
| mem_waddr | output | ADDR_W | Word address of the write |
| mem_wdata | output | 32 | Packed word |
| len_valid | output | 1 | Length queue not empty |
| len_data | output | LEN_W | Oldest queued frame length in bytes |
| len_pop | input | 1 | Remove the head length |
| rel_valid | input | 1 | Release a frame's space |
| rel_len | input | LEN_W | Byte length of the frame being released |

## Verification
The release input and frame acceptance can land in the same cycle, and both change the ring state: bottom moves under release, while top moves under acceptance. The bench brings the ring to a wrapped state where the queue holds one length, then ends a new good frame with that old length released in the very same cycle. The outcome is judged at the ports. The new length must be queued behind the popped one, and the following frame must start right after the accepted frame. Only ring space freed by the release can hold the following frames.

// File: rtl/rx_ring_pkg.sv
// Shared constants and helpers for the receive ring manager.
package rx_ring_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
endpackage

// File: rtl/rx_word_packer.sv
// Packs received bytes little-endian into 32-bit words and counts frame bytes.
// Assumes frame_end is raised for one cycle after the last byte; a partial word
// is emitted in that cycle with zero upper lanes.
module rx_word_packer
    import rx_ring_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              frame_end,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_data,
    output logic [LEN_W-1:0]  frame_len
);
    logic [WORD_W-1:0] acc_q;
    logic [1:0]        lane_q;
    logic [LEN_W-1:0]  len_q;
    logic [2:0]        lane_sum;

    // Merge the incoming byte into its lane and decide whether a word leaves.
    always_comb begin
        wr_data = acc_q;
        if (in_valid) wr_data[{lane_q, 3'b000} +: BYTE_W] = in_byte;
        lane_sum  = {1'b0, lane_q} + {2'b00, in_valid};
        wr_req    = (lane_sum == 3'd4) || (frame_end && (lane_sum != 3'd0));
        frame_len = len_q + LEN_W'(in_valid);
    end

    // Hold the partial word, lane index and running byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            lane_q <= '0;
            len_q  <= '0;
        end else begin
            if (wr_req || frame_end) begin
                acc_q  <= '0;
                lane_q <= '0;
            end else begin
                acc_q  <= wr_data;
                lane_q <= lane_sum[1:0];
            end
            len_q <= frame_end ? '0 : frame_len;
        end
    end

    // R3
    lane_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (lane_q == 2'd0) && (len_q == '0));
endmodule

// File: rtl/rx_len_fifo.sv
// Small synchronous FIFO of accepted frame lengths.
// Assumes push is never raised while full (the pointer unit guarantees it).
module rx_len_fifo #(
    parameter int LEN_W     = 12,
    parameter int FIFO_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LEN_W-1:0] push_len,
    input  logic             pop,
    output logic             head_valid,
    output logic [LEN_W-1:0] head_len,
    output logic             full
);
    localparam int DEPTH = 1 << FIFO_LOG2;

    logic [LEN_W-1:0]   slots [DEPTH];
    logic [FIFO_LOG2:0] wr_q, rd_q;
    logic               do_pop;

    // Derive flags from the extended pointers.
    always_comb begin
        head_valid = (wr_q != rd_q);
        full       = (wr_q[FIFO_LOG2-1:0] == rd_q[FIFO_LOG2-1:0]) &&
                     (wr_q[FIFO_LOG2] != rd_q[FIFO_LOG2]);
        head_len   = slots[rd_q[FIFO_LOG2-1:0]];
        do_pop     = pop && head_valid;
    end

    // Advance the pointers on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push)   wr_q <= wr_q + 1'b1;
            if (do_pop) rd_q <= rd_q + 1'b1;
        end
    end

    // Store pushed lengths.
    always_ff @(posedge clk) begin
        if (push) slots[wr_q[FIFO_LOG2-1:0]] <= push_len;
    end

    // R7
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R9
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !pop) |=> head_valid && $stable(head_len));
endmodule

// File: rtl/rx_ring_ptrs.sv
// Keeps bottom, top and write pointers of the receive ring; accepts a frame by
// copying the write pointer to top and rejects it by copying top back.
// Assumes releases arrive oldest first with the queued byte lengths.
module rx_ring_ptrs #(
    parameter int ADDR_W = 4,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              end_ok,
    input  logic              end_bad,
    input  logic              fifo_full,
    input  logic              rel_valid,
    input  logic [LEN_W-1:0]  rel_len,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              accept
);
    logic [ADDR_W-1:0] bottom_q, top_q, wptr_q, wptr_adv;
    logic              doomed_q, ring_full, blocked;
    logic [LEN_W-1:0]  rel_words;

    // Decide writes, overflow and frame acceptance for this cycle.
    always_comb begin
        ring_full = ((wptr_q + 1'b1) == bottom_q);
        blocked   = wr_req && (doomed_q || ring_full);
        mem_we    = wr_req && !doomed_q && !ring_full;
        mem_waddr = wptr_q;
        wptr_adv  = mem_we ? wptr_q + 1'b1 : wptr_q;
        accept    = end_ok && !end_bad && !doomed_q && !blocked && !fifo_full;
        rel_words = (rel_len + LEN_W'(3)) >> 2;
    end

    // Update the write pointer, top and the overflow mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q    <= '0;
            wptr_q   <= '0;
            doomed_q <= 1'b0;
        end else if (accept) begin
            top_q    <= wptr_adv;
            wptr_q   <= wptr_adv;
            doomed_q <= 1'b0;
        end else if (end_ok || end_bad) begin
            wptr_q   <= top_q;
            doomed_q <= 1'b0;
        end else begin
            wptr_q   <= wptr_adv;
            doomed_q <= doomed_q || blocked;
        end
    end

    // Advance bottom by the released word count.
    always_ff @(posedge clk) begin
        if (!rst_n)         bottom_q <= '0;
        else if (rel_valid) bottom_q <= bottom_q + rel_words[ADDR_W-1:0];
    end

    // R6
    doomed_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        doomed_q |-> !mem_we);
    // R5
    reject_rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_bad && !end_ok) |=> (wptr_q == top_q));
    // R8
    region_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ADDR_W'(wptr_q - bottom_q) >= ADDR_W'(top_q - bottom_q)));
    // R4
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !doomed_q && (wptr_q == top_q));
endmodule

// File: rtl/rx_ring_mgr.sv
// Top of the receive ring manager: packer, pointer unit and length queue.
// Assumes frame_ok/frame_bad are single-cycle pulses in cycles without a byte.
module rx_ring_mgr
    import rx_ring_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int LEN_W     = 12,
    parameter int FIFO_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              frame_ok,
    input  logic              frame_bad,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [31:0]       mem_wdata,
    output logic              len_valid,
    output logic [LEN_W-1:0]  len_data,
    input  logic              len_pop,
    input  logic              rel_valid,
    input  logic [LEN_W-1:0]  rel_len
);
    logic             wr_req, accept, fifo_full, frame_end;
    logic [LEN_W-1:0] frame_len;

    assign frame_end = frame_ok || frame_bad;

    rx_word_packer #(.LEN_W(LEN_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .frame_end(frame_end), .wr_req(wr_req), .wr_data(mem_wdata),
        .frame_len(frame_len)
    );

    rx_ring_ptrs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .end_ok(frame_ok),
        .end_bad(frame_bad), .fifo_full(fifo_full), .rel_valid(rel_valid),
        .rel_len(rel_len), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .accept(accept)
    );

    rx_len_fifo #(.LEN_W(LEN_W), .FIFO_LOG2(FIFO_LOG2)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(accept), .push_len(frame_len),
        .pop(len_pop), .head_valid(len_valid), .head_len(len_data),
        .full(fifo_full)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !len_valid);
endmodule

// File: tb/rx_ring_mgr_bench.sv
module rx_ring_mgr_bench;
    localparam int AW = 4;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, frame_ok = 1'b0, frame_bad = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          mem_we, len_valid, len_pop = 1'b0, rel_valid = 1'b0;
    logic [AW-1:0] mem_waddr;
    logic [31:0]   mem_wdata;
    logic [LW-1:0] len_data, rel_len = '0;

    int checks = 0, fails = 0, writes = 0;
    logic [AW-1:0] first_addr;
    logic          seen_first = 1'b0;
    logic [31:0]   mem [16];

    always #4 clk = ~clk;

    rx_ring_mgr u_rx_ring_mgr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .frame_ok(frame_ok), .frame_bad(frame_bad), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .len_valid(len_valid),
        .len_data(len_data), .len_pop(len_pop), .rel_valid(rel_valid),
        .rel_len(rel_len)
    );

    // Bench-side ring memory and write observer.
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_waddr] <= mem_wdata;
            writes <= writes + 1;
            if (!seen_first) begin
                first_addr <= mem_waddr;
                seen_first <= 1'b1;
            end
        end
    end

    initial begin
        #1500000;
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Send n bytes (base+i), then an end pulse; optional release in the end cycle.
    task automatic send_frame(input int n, input logic [7:0] base, input bit good,
                              input bit rel, input logic [LW-1:0] rlen);
        @(negedge clk);
        writes = 0;
        seen_first = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_byte  = base + 8'(i);
            @(negedge clk);
        end
        in_valid  = 1'b0;
        frame_ok  = good;
        frame_bad = !good;
        rel_valid = rel;
        rel_len   = rlen;
        @(negedge clk);
        frame_ok  = 1'b0;
        frame_bad = 1'b0;
        rel_valid = 1'b0;
    endtask

    task automatic pop_len();
        len_pop = 1'b1;
        @(negedge clk);
        len_pop = 1'b0;
    endtask

    task automatic release_len(input logic [LW-1:0] l);
        rel_valid = 1'b1;
        rel_len   = l;
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    function automatic logic [31:0] pack4(input logic [7:0] b);
        return {b + 8'd3, b + 8'd2, b + 8'd1, b};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(!len_valid, "R1 len_valid after reset", len_valid, 0);
        chk(!mem_we, "R1 no write after reset", mem_we, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_good_frames();
        send_frame(8, 8'h10, 1'b1, 1'b0, '0);
        chk(first_addr == 0, "R1 first frame at 0", first_addr, 0);
        chk(mem[0] == pack4(8'h10), "R2 word0 packing", mem[0], pack4(8'h10));
        chk(mem[1] == pack4(8'h14), "R2 word1 packing", mem[1], pack4(8'h14));
        chk(len_valid && len_data == 8, "R4 length queued", len_data, 8);
        send_frame(6, 8'h40, 1'b1, 1'b0, '0);
        chk(first_addr == 2, "R4 next frame after accepted", first_addr, 2);
        chk(mem[3] == 32'h0000_4544, "R3 partial word zero filled", mem[3], 32'h0000_4544);
    endtask

    task automatic t_bad_frame();
        send_frame(5, 8'h70, 1'b0, 1'b0, '0);
        chk(first_addr == 4 && writes == 2, "R5 rejected frame written at 4", first_addr, 4);
        send_frame(4, 8'h80, 1'b1, 1'b0, '0);
        chk(first_addr == 4, "R5 next frame reuses address", first_addr, 4);
        chk(mem[4] == pack4(8'h80), "R5 overwrite content", mem[4], pack4(8'h80));
    endtask

    task automatic t_dequeue();
        chk(len_data == 8, "R9 head is oldest", len_data, 8);
        pop_len();
        chk(len_data == 6, "R9 pop advances (6)", len_data, 6);
        pop_len();
        chk(len_data == 4, "R9 pop advances (4); R5 nothing queued for bad", len_data, 4);
        pop_len();
        chk(!len_valid, "R9 queue empty", len_valid, 0);
        release_len(8);
        release_len(6);
        release_len(4);
    endtask

    task automatic t_wrap_and_full();
        send_frame(48, 8'h00, 1'b1, 1'b0, '0);
        chk(first_addr == 5 && writes == 12, "R8 wrapping frame 12 words", writes, 12);
        chk(mem[0] == pack4(8'd44), "R2 wrapped word at 0", mem[0], pack4(8'd44));
        send_frame(16, 8'hA0, 1'b1, 1'b0, '0);
        chk(writes == 3, "R6 stop before bottom", writes, 3);
        chk(len_valid && len_data == 48, "R6 overflow frame not queued (head)", len_data, 48);
        pop_len();
        chk(!len_valid, "R6 overflow frame not queued", len_valid, 0);
    endtask

    task automatic t_release_with_accept();
        send_frame(8, 8'hC0, 1'b1, 1'b1, 12'd48);
        chk(first_addr == 1, "R6 rejected space reused", first_addr, 1);
        chk(len_valid && len_data == 8, "R10 accept with release", len_data, 8);
        pop_len();
        release_len(8);
        send_frame(16, 8'hD0, 1'b1, 1'b0, '0);
        chk(first_addr == 3 && writes == 4, "R10 space freed by release", writes, 4);
    endtask

    task automatic t_fifo_full();
        send_frame(4, 8'h01, 1'b1, 1'b0, '0);
        send_frame(4, 8'h02, 1'b1, 1'b0, '0);
        send_frame(4, 8'h03, 1'b1, 1'b0, '0);
        send_frame(4, 8'h04, 1'b1, 1'b0, '0);
        chk(first_addr == 10 && writes == 1, "R7 written before reject", first_addr, 10);
        chk(len_data == 16, "R7 head unchanged", len_data, 16);
        for (int i = 0; i < 4; i++) pop_len();
        chk(!len_valid, "R7 exactly four queued", len_valid, 0);
        send_frame(4, 8'h05, 1'b1, 1'b0, '0);
        chk(first_addr == 10, "R7 rejected address reused", first_addr, 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_good_frames();
        t_bad_frame();
        t_dequeue();
        t_wrap_and_full();
        t_release_with_accept();
        t_fifo_full();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule